// File: doc/BRIEF.md
# SPI Register-Access Slave

This block connects an external SPI master to an 8-bit register bank inside the chip. Every transfer opens with a command byte that carries a direction flag, an address-step flag and a 6-bit register address. One or more data bytes follow it, and all bits travel MSB first.

The pins are oversampled by the fast system clock. This means the whole block lives in one clock domain, and the register bank sees single-cycle write and read strobes.

A configuration input chooses where read data is returned:
- In 4-wire mode it goes on a dedicated output pin.
- In 3-wire mode the single data line turns around at the first data bit, and read data goes out on that shared line.

Only one clock mode is supported: the serial clock idles high, data changes on the falling edge and data is captured on the rising edge.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, and while chip select is high, both output enables are low and no register strobe is issued.
- R2: The first byte of a frame is decoded with its first bit as the direction flag (1 = read, 0 = write), its second bit as the step flag (1 = advance the address per data byte), and its last six bits as the register address, MSB first.
- R3: In a write frame, each complete data byte, assembled MSB first, is written to the current address with one `reg_wr` pulse. The pulse follows the sixteenth rising edge for the first byte, and each further eighth rising edge for later bytes.
- R4: In a read frame, `reg_rd` pulses once per data byte at the falling edge that starts that byte. The register value then appears MSB first on `spi_dout`, with an output enable high from the start of the first data bit.
- R5: When the step flag is 1, the address increases by one after each data byte, for both reads and writes. It wraps from 63 to 0.
- R6: When the step flag is 0, every data byte of a burst uses the command's address.
- R7: With `three_wire` = 1 the read enable is raised on `sdio_oe` and not on `sdo_oe`. With `three_wire` = 0 the reverse holds.
- R8: Chip select going high at any point drops the output enable and restarts the bit count. The next frame is then decoded from its own first bit.
- R9: A data byte cut short by chip select rising produces no write, while the bytes completed earlier in the frame are kept.
- R10: Each `reg_wr` pulse lasts one cycle, and `reg_wr` and `reg_rd` are never high together. A write frame issues no `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select framing a transfer |
| spi_sck | input | 1 | Serial clock, idle high |
| spi_sdi | input | 1 | Serial data in (the shared line in 3-wire mode) |
| three_wire | input | 1 | 1 selects the shared-line read mode |
| spi_dout | output | 1 | Read data bit for whichever pin is enabled |
| sdo_oe | output | 1 | Output enable of the dedicated data-out pin |
| sdio_oe | output | 1 | Output enable of the shared data line |
| reg_addr | output | 6 | Register address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Value of the register at `reg_addr`, valid the cycle `reg_rd` is high |

## Verification
The assertions check a set of rules on every cycle:
- An idle chip select forces both enables low.
- Strobes are single-cycle and never overlap.
- Every read strobe is followed by the output enable of the selected pin, and only that one.

Address decoding, MSB-first data order, the address step with wrap-around, the fixed-address burst, and the dropping of partial bytes are all properties of whole frames. Only the bench's scenarios show them, by comparing the bench's own register model and received bytes against values computed from the address. The sweeps cover every address in writes and reads, with reads alternating between the two pin modes. They also cover bursts that cross the top address, and frames aborted inside the command byte and inside a data byte.

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int DATA_W = 8,
  parameter int SYNC   = 2,
  localparam int ADDR_W = DATA_W - 2,
  localparam int CW     = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  input  logic              three_wire,
  output logic              spi_dout,
  output logic              sdo_oe,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam logic [CW-1:0] CMD_END   = CW'(DATA_W - 1);
  localparam logic [CW-1:0] DAT_START = CW'(DATA_W);
  localparam logic [CW-1:0] LAST      = CW'(2 * DATA_W - 1);

  logic [SYNC-1:0]   cs_p, sck_p, di_p;
  logic              sck_q;
  logic [CW-1:0]     cnt;
  logic [DATA_W-2:0] sh;
  logic [DATA_W-1:0] tx;
  logic              rw, ms, adv, oe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '1;
      di_p  <= '0;
      sck_q <= 1'b1;
    end else begin
      cs_p  <= {cs_p[SYNC-2:0], spi_cs_n};
      sck_p <= {sck_p[SYNC-2:0], spi_sck};
      di_p  <= {di_p[SYNC-2:0], spi_sdi};
      sck_q <= sck_p[SYNC-1];
    end

  wire cs_s  = cs_p[SYNC-1];
  wire sck_s = sck_p[SYNC-1];
  wire din   = di_p[SYNC-1];
  wire rise  = !cs_s && sck_s && !sck_q;
  wire fall  = !cs_s && !sck_s && sck_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      ms        <= 1'b0;
      adv       <= 1'b0;
      oe        <= 1'b0;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      adv    <= 1'b0;
      if (adv) reg_addr <= reg_addr + 1'b1;
      if (cs_s) begin
        cnt <= '0;
        oe  <= 1'b0;
      end else begin
        if (rise) begin
          sh  <= {sh[DATA_W-3:0], din};
          cnt <= (cnt == LAST) ? DAT_START : cnt + 1'b1;
          if (cnt == CMD_END) begin
            rw       <= sh[DATA_W-2];
            ms       <= sh[DATA_W-3];
            reg_addr <= {sh[ADDR_W-2:0], din};
          end
          if (cnt == LAST) begin
            adv <= ms;
            if (!rw) begin
              reg_wr    <= 1'b1;
              reg_wdata <= {sh, din};
            end
          end
        end
        if (fall && rw && cnt == DAT_START) begin
          tx     <= reg_rdata;
          reg_rd <= 1'b1;
          oe     <= 1'b1;
        end else if (fall) begin
          tx <= {tx[DATA_W-2:0], 1'b0};
        end
      end
    end

  assign spi_dout = tx[DATA_W-1];
  assign sdo_oe   = oe & ~three_wire;
  assign sdio_oe  = oe & three_wire;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic three_wire,
  input logic sdo_oe,
  input logic sdio_oe,
  input logic reg_wr,
  input logic reg_rd
);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!sdo_oe && !sdio_oe));

  p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  p_rd_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (sdo_oe || sdio_oe));

  p_pin_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && $stable(three_wire)) |=>
      (three_wire ? (sdio_oe && !sdo_oe) : (sdo_oe && !sdio_oe)));

  p_oe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sdo_oe, sdio_oe}));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .three_wire(three_wire),
  .sdo_oe(sdo_oe), .sdio_oe(sdio_oe), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b1, sdi = 1'b0, tw = 1'b0;
  logic dout, oe4, oe3, reg_wr, reg_rd;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [64];
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  int wr_cnt, rd_cnt, checks, fails;
  bit oe_bad;

  always #2.5 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
    .three_wire(tw), .spi_dout(dout), .sdo_oe(oe4), .sdio_oe(oe3),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
      wr_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic rw, input logic ms, input logic [5:0] ad,
                      input int nbytes, input logic mode, input int maxbits);
    int nb = 0;
    logic [7:0] cur;
    oe_bad = 1'b0;
    @(negedge clk);
    tw = mode;
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i <= nbytes; i++) begin
      cur = (i == 0) ? {rw, ms, ad} : txb[i-1];
      for (int b = 7; b >= 0; b--) begin
        if (nb < maxbits) begin
          sck = 1'b0;
          sdi = cur[b];
          repeat (HP) @(negedge clk);
          if (i > 0 && rw) begin
            rxb[i-1][b] = dout;
            if (mode ? !(oe3 && !oe4) : !(oe4 && !oe3)) oe_bad = 1'b1;
          end
          sck = 1'b1;
          repeat (HP) @(negedge clk);
          nb++;
        end
      end
    end
    cs_n = 1'b1;
    repeat (3 * HP) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!oe4 && !oe3, "R1 enables after reset", {oe4, oe3}, 0);
    chk(wr_cnt == 0 && rd_cnt == 0, "R1 strobes after reset", wr_cnt + rd_cnt, 0);

    r0 = rd_cnt;
    for (int a = 0; a < 64; a++) begin
      txb[0] = pat(a);
      w0 = wr_cnt;
      xfer(1'b0, 1'b0, 6'(a), 1, 1'b0, 999);
      chk(mem[a] == pat(a), "R2 R3 single write", mem[a], pat(a));
      chk(wr_cnt == w0 + 1, "R3 one write strobe", wr_cnt - w0, 1);
    end
    chk(rd_cnt == r0, "R10 no read strobe in writes", rd_cnt - r0, 0);

    for (int a = 0; a < 64; a++) begin
      r0 = rd_cnt;
      w0 = wr_cnt;
      xfer(1'b1, 1'b0, 6'(a), 1, a[0], 999);
      chk(rxb[0] == pat(a), "R2 R4 single read", rxb[0], pat(a));
      chk(!oe_bad, "R7 enable on selected pin", oe_bad, 0);
      chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R4 one read strobe", rd_cnt - r0, 1);
    end

    for (int k = 0; k < 4; k++) txb[k] = 8'hA0 + 8'(k);
    w0 = wr_cnt;
    xfer(1'b0, 1'b1, 6'd62, 4, 1'b0, 999);
    for (int k = 0; k < 4; k++)
      chk(mem[(62 + k) & 63] == 8'hA0 + 8'(k), "R5 stepped write wrap",
          mem[(62 + k) & 63], 8'hA0 + k);
    chk(wr_cnt == w0 + 4, "R5 write count", wr_cnt - w0, 4);

    xfer(1'b1, 1'b1, 6'd62, 4, 1'b1, 999);
    for (int k = 0; k < 4; k++)
      chk(rxb[k] == 8'hA0 + 8'(k), "R5 stepped read wrap", rxb[k], 8'hA0 + k);
    chk(!oe_bad, "R7 burst read 3-wire", oe_bad, 0);

    txb[0] = 8'd11; txb[1] = 8'd22; txb[2] = 8'd33;
    xfer(1'b0, 1'b0, 6'd10, 3, 1'b0, 999);
    chk(mem[10] == 8'd33, "R6 fixed-address write", mem[10], 33);
    chk(mem[11] == pat(11), "R6 neighbour untouched", mem[11], pat(11));
    xfer(1'b1, 1'b0, 6'd10, 3, 1'b0, 999);
    for (int k = 0; k < 3; k++)
      chk(rxb[k] == 8'd33, "R6 fixed-address read", rxb[k], 33);

    w0 = wr_cnt;
    txb[0] = 8'hFF;
    xfer(1'b0, 1'b0, 6'd20, 1, 1'b0, 13);
    chk(wr_cnt == w0, "R9 partial byte no strobe", wr_cnt - w0, 0);
    chk(mem[20] == pat(20), "R9 partial byte value", mem[20], pat(20));

    w0 = wr_cnt;
    txb[0] = 8'h5A; txb[1] = 8'h3C;
    xfer(1'b0, 1'b1, 6'd30, 2, 1'b0, 19);
    chk(mem[30] == 8'h5A, "R9 completed byte kept", mem[30], 8'h5A);
    chk(mem[31] == pat(31), "R9 cut byte dropped", mem[31], pat(31));
    chk(wr_cnt == w0 + 1, "R9 strobe count", wr_cnt - w0, 1);

    xfer(1'b1, 1'b0, 6'd5, 1, 1'b0, 11);
    chk(!oe4 && !oe3, "R8 enable drops on abort", {oe4, oe3}, 0);
    xfer(1'b1, 1'b0, 6'd5, 1, 1'b0, 999);
    chk(rxb[0] == pat(5), "R8 frame after abort", rxb[0], pat(5));

    xfer(1'b0, 1'b0, 6'd7, 1, 1'b0, 5);
    txb[0] = 8'h81;
    xfer(1'b0, 1'b0, 6'd7, 1, 1'b0, 999);
    chk(mem[7] == 8'h81, "R8 abort inside command", mem[7], 8'h81);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule